// File: doc/BRIEF.md
# No-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM built so the data bus never idles when traffic switches between reads and writes. A single write-enable pin chooses the direction of each access, and per-lane active-low byte enables select which 9-bit lanes (8 data bits plus parity) a write touches. Reads are flow-through: once an address is registered on a rising edge, its word is on the read-data port in that same cycle. Writes are late: the command and address are registered on one edge and the write data with its byte enables on the next active edge. The write data is held in a pending-write register. A read that hits it sees the new bytes merged over the stored word.

Each access can grow into a four-beat burst. While the advance input is high, the block repeats the last command type at the next internal address. The two low address bits step through a linear or an interleaved order and then wrap to the start. A clock-enable input freezes the whole block, and three chip selects gate every new command. Instead of a tristate bus, the block presents read data together with an output-drive flag. That flag follows the output-enable pin without waiting for a clock.

Top module: `nt_sram_flow`

## Requirements
- R1: A new command is taken on a rising edge only when clk_en_ni=0, advance_i=0, sel1_ni=0, sel2_i=1 and sel3_ni=0. If advance_i=0 and any select is inactive, that edge deselects the device and drive_o stays 0.
- R2: After an edge that loads a read (we_ni=1), rdata_o carries the word at the loaded address in the same cycle. drive_o is 1 exactly while that read is current and oe_ni=0, and it follows oe_ni with no clock edge.
- R3: A write command (we_ni=0) registers its address on one edge, and the data and byte enables on wdata_i/be_ni are taken at the next active edge.
- R4: be_ni bit k (active low) enables lane k, which is wdata_i bits [9k+8:9k]. Unselected lanes keep their old contents. A write with all be_ni bits high changes no lane, but the burst still moves to the next address.
- R5: With order_i=0, a burst steps the two low address bits linearly (start, +1, +2, +3 modulo 4) and wraps to the start value on the fifth beat. The upper address bits stay fixed.
- R6: With order_i=1, the burst's low address bits equal the start value XOR the beat count, so a start of 01 gives 01, 00, 11, 10.
- R7: advance_i=1 on an active edge continues the current read or write burst at its next address without sampling selects or we_ni. After a deselect it keeps the device deselected.
- R8: While clk_en_ni=1, all inputs are ignored and the current address, command state and pending write hold. A write's data is taken at the next edge that has clk_en_ni=0.
- R9: A read of the address whose late write is still pending returns the enabled new bytes merged over the stored word.
- R10: While rst_ni=0 and after its release, the device is deselected with drive_o=0 and no pending write.
- R11: drive_o is 0 during write cycles whatever the state of oe_ni.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low; high freezes the block |
| sel1_ni | input | 1 | Chip select 1, active low |
| sel2_i | input | 1 | Chip select 2, active high |
| sel3_ni | input | 1 | Chip select 3, active low |
| advance_i | input | 1 | 1 continues the burst, 0 loads a new command |
| we_ni | input | 1 | 0 write, 1 read |
| be_ni | input | LANES | Byte-lane write enables, active low |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_i | input | AW | Word address |
| wdata_i | input | LANES*9 | Late write data |
| rdata_o | output | LANES*9 | Flow-through read data |
| drive_o | output | 1 | Read data is being driven |

## Verification
The bench first reads the burst sequences from the odd start address 5 in both orders, including the wrap beat. A generator that carried into the upper bits, or mixed up the two orders, would return the wrong words there. It then reads back an address in the very edge that delivers its late write, both fully and with alternating lanes. A design without the merge would return the stale word, and one that ignored a lane enable would corrupt a kept lane. Clock-enable stalls are placed between a write command and its data, and also in the middle of a read burst. A design that captured data during the stall would store garbage, and one that advanced during the stall would skip a beat. Aborted writes, one bad select at a time, continue-deselect and a long random mixed run against a bench model cover the rest.

// File: rtl/nt_sram_pkg.sv
package nt_sram_pkg;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned BEAT_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10
  } op_e;
endpackage

// File: rtl/nt_cmd_ctrl.sv
module nt_cmd_ctrl
  import nt_sram_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic load_i,
  input  logic sel_ok_i,
  input  logic we_ni,
  output op_e  op_o,
  output logic load_o,
  output logic bump_o
);
  op_e op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= OP_IDLE;
    end else if (step_i && load_i) begin
      if (sel_ok_i) op_q <= we_ni ? OP_READ : OP_WRITE;
      else          op_q <= OP_IDLE;
    end
  end

  assign op_o   = op_q;
  assign load_o = step_i && load_i && sel_ok_i;
  // continue only a live burst; idle stays idle
  assign bump_o = step_i && !load_i && (op_q != OP_IDLE);
endmodule

// File: rtl/nt_burst_gen.sv
module nt_burst_gen
  import nt_sram_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          bump_i,
  input  logic          order_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned HI_W = AW - BEAT_W;

  logic [HI_W-1:0]   hi_q;
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      start_q <= '0;
      beat_q  <= '0;
    end else if (load_i) begin
      hi_q    <= addr_i[AW-1:BEAT_W];
      start_q <= addr_i[BEAT_W-1:0];
      beat_q  <= '0;
    end else if (bump_i) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  always_comb begin
    if (order_i) low = start_q ^ beat_q;
    else         low = start_q + beat_q;
  end

  assign addr_o = {hi_q, low};
endmodule

// File: rtl/nt_write_stage.sv
module nt_write_stage
  import nt_sram_pkg::*;
#(
  parameter  int unsigned AW    = 6,
  parameter  int unsigned LANES = 4,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             capture_i,
  input  logic [AW-1:0]    cap_addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [LANES-1:0] be_ni,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic [DW-1:0]    arr_data_i,
  output logic [DW-1:0]    merged_o,
  output logic             cm_en_o,
  output logic [AW-1:0]    cm_addr_o,
  output logic [DW-1:0]    cm_data_o,
  output logic [LANES-1:0] cm_mask_o
);
  logic             valid_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    data_q;
  logic [LANES-1:0] mask_q;
  logic             hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      mask_q  <= '0;
    end else if (step_i) begin
      valid_q <= capture_i;
      if (capture_i) begin
        addr_q <= cap_addr_i;
        data_q <= wdata_i;
        mask_q <= ~be_ni;
      end
    end
  end

  // previous pending word retires on the same edge a new one is captured
  assign cm_en_o   = step_i && valid_q;
  assign cm_addr_o = addr_q;
  assign cm_data_o = data_q;
  assign cm_mask_o = mask_q;

  assign hit = valid_q && (addr_q == rd_addr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign merged_o[l*LANE_W +: LANE_W] = (hit && mask_q[l]) ?
        data_q[l*LANE_W +: LANE_W] : arr_data_i[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/nt_sram_array.sv
module nt_sram_array
  import nt_sram_pkg::*;
#(
  parameter  int unsigned DEPTH = 64,
  parameter  int unsigned LANES = 4,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [LANES-1:0] wmask_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && wmask_i[l]) mem_q[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem_q[raddr_i];
  end
endmodule

// File: rtl/nt_sram_flow.sv
module nt_sram_flow
  import nt_sram_pkg::*;
#(
  parameter  int unsigned LANES = 4,
  parameter  int unsigned DEPTH = 64,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_ni,
  input  logic             sel1_ni,
  input  logic             sel2_i,
  input  logic             sel3_ni,
  input  logic             advance_i,
  input  logic             we_ni,
  input  logic [LANES-1:0] be_ni,
  input  logic             oe_ni,
  input  logic             order_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             drive_o
);
  logic             step;
  logic             sel_ok;
  op_e              op;
  logic             load;
  logic             bump;
  logic [AW-1:0]    cur_addr;
  logic             capture;
  logic [DW-1:0]    arr_data;
  logic             cm_en;
  logic [AW-1:0]    cm_addr;
  logic [DW-1:0]    cm_data;
  logic [LANES-1:0] cm_mask;

  assign step   = !clk_en_ni;
  assign sel_ok = !sel1_ni && sel2_i && !sel3_ni;

  nt_cmd_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step),
    .load_i   (!advance_i),
    .sel_ok_i (sel_ok),
    .we_ni    (we_ni),
    .op_o     (op),
    .load_o   (load),
    .bump_o   (bump)
  );

  nt_burst_gen #(.AW(AW)) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .bump_i  (bump),
    .order_i (order_i),
    .addr_i  (addr_i),
    .addr_o  (cur_addr)
  );

  // data of the current write beat arrives on this edge
  assign capture = step && (op == OP_WRITE);

  nt_write_stage #(.AW(AW), .LANES(LANES)) u_wstage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .capture_i  (capture),
    .cap_addr_i (cur_addr),
    .wdata_i    (wdata_i),
    .be_ni      (be_ni),
    .rd_addr_i  (cur_addr),
    .arr_data_i (arr_data),
    .merged_o   (rdata_o),
    .cm_en_o    (cm_en),
    .cm_addr_o  (cm_addr),
    .cm_data_o  (cm_data),
    .cm_mask_o  (cm_mask)
  );

  nt_sram_array #(.DEPTH(DEPTH), .LANES(LANES)) u_array (
    .clk_i   (clk_i),
    .we_i    (cm_en),
    .waddr_i (cm_addr),
    .wmask_i (cm_mask),
    .wdata_i (cm_data),
    .raddr_i (cur_addr),
    .rdata_o (arr_data)
  );

  assign drive_o = (op == OP_READ) && !oe_ni;
endmodule

// File: rtl/nt_sram_flow_chk.sv
module nt_sram_flow_chk #(
  parameter int unsigned AW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clk_en_ni,
  input logic          sel1_ni,
  input logic          sel2_i,
  input logic          sel3_ni,
  input logic          advance_i,
  input logic          we_ni,
  input logic          oe_ni,
  input logic          drive_o,
  input logic [1:0]    op_i,
  input logic [AW-1:0] cur_addr_i
);
  logic pins_sel;
  assign pins_sel = !sel1_ni && sel2_i && !sel3_ni;

  // R2
  drive_needs_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> !oe_ni);

  // R1
  deselect_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && !advance_i && !pins_sel) |=> !drive_o);

  // R11
  write_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && !advance_i && pins_sel && !we_ni) |=> !drive_o);

  // R8
  hold_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_ni |=> ($stable(cur_addr_i) && $stable(op_i)));

  // R7
  burst_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_ni && advance_i) |=> ($stable(cur_addr_i[AW-1:2]) && $stable(op_i)));
endmodule

bind nt_sram_flow nt_sram_flow_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clk_en_ni  (clk_en_ni),
  .sel1_ni    (sel1_ni),
  .sel2_i     (sel2_i),
  .sel3_ni    (sel3_ni),
  .advance_i  (advance_i),
  .we_ni      (we_ni),
  .oe_ni      (oe_ni),
  .drive_o    (drive_o),
  .op_i       (op),
  .cur_addr_i (cur_addr)
);

// File: tb/nt_sram_flow_tb.sv
module nt_sram_flow_tb_top;
  localparam int unsigned LANES = 4;
  localparam int unsigned DEPTH = 64;
  localparam int unsigned AW    = 6;
  localparam int unsigned DW    = LANES * 9;
  localparam logic [2:0]  SEL_ON  = 3'b010;
  localparam logic [2:0]  SEL_OFF = 3'b110;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             clk_en_n, sel1_n, sel2, sel3_n, advance, we_n, oe_n, order;
  logic [LANES-1:0] be_n;
  logic [AW-1:0]    addr;
  logic [DW-1:0]    wdata;
  logic [DW-1:0]    rdata;
  logic             drive;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench model
  int            m_op = 0;  // 0 idle, 1 read, 2 write
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic [DW-1:0] m_mem [DEPTH];

  always #10 clk = ~clk;

  nt_sram_flow #(.LANES(LANES), .DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_ni(clk_en_n), .sel1_ni(sel1_n),
    .sel2_i(sel2), .sel3_ni(sel3_n), .advance_i(advance), .we_ni(we_n),
    .be_ni(be_n), .oe_ni(oe_n), .order_i(order), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .drive_o(drive)
  );

  function automatic logic [DW-1:0] pat(input int a);
    logic [DW-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*9 +: 9] = 9'(a * 7 + l * 61 + 5);
    return v;
  endfunction

  function automatic logic [AW-1:0] m_cur();
    logic [1:0] lo;
    lo = order ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic ce_n, input logic adv,
                     input logic [2:0] sel, input logic w_n, input logic [AW-1:0] ad,
                     input logic [DW-1:0] wd, input logic [LANES-1:0] bn, input logic o_n);
    logic [AW-1:0] ca;
    clk_en_n = ce_n; advance = adv; {sel1_n, sel2, sel3_n} = sel; we_n = w_n;
    addr = ad; wdata = wd; be_n = bn; oe_n = o_n;
    if (!ce_n) begin
      if (m_op == 2) begin
        ca = m_cur();
        for (int l = 0; l < LANES; l++)
          if (!bn[l]) m_mem[ca][l*9 +: 9] = wd[l*9 +: 9];
      end
      if (!adv) begin
        if (sel == SEL_ON) begin
          m_op = w_n ? 1 : 2; m_base = ad; m_beat = '0;
        end else m_op = 0;
      end else if (m_op != 0) m_beat = m_beat + 2'd1;
    end
    @(posedge clk); #5;
    chk(tag, DW'(drive), DW'(m_op == 1 && !o_n));
    if (m_op == 1 && !o_n) chk(tag, rdata, m_mem[m_cur()]);
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] ad);
    cyc(tag, 1'b0, 1'b0, SEL_ON, 1'b1, ad, '0, '1, 1'b0);
  endtask

  task automatic nxt(input string tag, input logic [DW-1:0] wd, input logic [LANES-1:0] bn);
    cyc(tag, 1'b0, 1'b1, 3'b111, 1'b1, '0, wd, bn, 1'b0);
  endtask

  task automatic wcmd(input string tag, input logic [AW-1:0] ad);
    cyc(tag, 1'b0, 1'b0, SEL_ON, 1'b0, ad, '0, '1, 1'b0);
  endtask

  task automatic dsel(input string tag, input logic [DW-1:0] wd, input logic [LANES-1:0] bn);
    cyc(tag, 1'b0, 1'b0, SEL_OFF, 1'b1, '0, wd, bn, 1'b0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d, old, ex;
    void'($urandom(32'd4242));
    rst_n = 1'b0; clk_en_n = 1'b0; advance = 1'b0; {sel1_n, sel2, sel3_n} = SEL_OFF;
    we_n = 1'b1; be_n = '1; oe_n = 1'b0; order = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #5;
    chk("R10", DW'(drive), '0);
    rst_n = 1'b1;
    chk("R10", DW'(drive), '0);

    // R7: continue-deselect straight after reset
    nxt("R7", '0, '1);
    chk("R7", DW'(drive), '0);

    // R3: fill the array with linear write bursts, data one edge late
    for (int i = 0; i <= 64; i++) begin
      d = (i > 0) ? pat(i - 1) : '0;
      if (i == 64)         dsel("R3", d, '0);
      else if (i % 4 == 0) cyc("R3", 1'b0, 1'b0, SEL_ON, 1'b0, AW'(i), d, (i > 0) ? '0 : '1, 1'b0);
      else                 cyc("R3", 1'b0, 1'b1, 3'b111, 1'b0, '0, d, '0, 1'b0);
    end

    // R5: linear from 5 -> 5,6,7,4, then wrap to 5
    rd("R5", 6'd5); chk("R5", rdata, pat(5));
    nxt("R5", '0, '1); chk("R5", rdata, pat(6));
    nxt("R5", '0, '1); chk("R5", rdata, pat(7));
    nxt("R5", '0, '1); chk("R5", rdata, pat(4));
    nxt("R5", '0, '1); chk("R5", rdata, pat(5));

    // R6: interleaved from 5 -> 5,4,7,6
    order = 1'b1;
    rd("R6", 6'd5); chk("R6", rdata, pat(5));
    nxt("R6", '0, '1); chk("R6", rdata, pat(4));
    nxt("R6", '0, '1); chk("R6", rdata, pat(7));
    nxt("R6", '0, '1); chk("R6", rdata, pat(6));
    order = 1'b0;

    // R2: output enable acts without a clock
    rd("R2", 6'd10); chk("R2", rdata, pat(10));
    oe_n = 1'b1; #1; chk("R2", DW'(drive), '0);
    oe_n = 1'b0; #1; chk("R2", DW'(drive), 1);

    // R11 and R8: write with a stall between command and data
    wcmd("R11", 6'd20); chk("R11", DW'(drive), '0);
    cyc("R8", 1'b1, 1'b0, SEL_ON, 1'b0, 6'd3, '1, '0, 1'b0);
    chk("R8", DW'(drive), '0);
    d = 36'h1_2345_6789;
    dsel("R8", d, '0);
    rd("R8", 6'd20); chk("R8", rdata, d);
    rd("R8", 6'd3);  chk("R8", rdata, pat(3));

    // R8: stall inside a read burst
    rd("R8", 6'd8); chk("R8", rdata, pat(8));
    cyc("R8", 1'b1, 1'b0, SEL_ON, 1'b1, 6'd50, '0, '1, 1'b0);
    chk("R8", rdata, pat(8));
    nxt("R8", '0, '1); chk("R8", rdata, pat(9));

    // R9: read in the very edge that delivers the write data
    wcmd("R9", 6'd30);
    d = 36'hA_BCDE_F012;
    cyc("R9", 1'b0, 1'b0, SEL_ON, 1'b1, 6'd30, d, '0, 1'b0);
    chk("R9", rdata, d);

    // R4: lanes 0 and 2 written (be_ni = 1010), merged then committed
    wcmd("R4", 6'd31);
    d = 36'h5_5AA5_A55A;
    old = pat(31);
    ex = {old[35:27], d[26:18], old[17:9], d[8:0]};
    cyc("R4", 1'b0, 1'b0, SEL_ON, 1'b1, 6'd31, d, 4'b1010, 1'b0);
    chk("R4", rdata, ex);
    dsel("R4", '0, '1);
    rd("R4", 6'd31); chk("R4", rdata, ex);

    // R4: aborted beat keeps old data, burst still advances
    wcmd("R4", 6'd40);
    nxt("R4", 36'hF_FFFF_FFFF, '1);
    d = 36'h0_0F0F_0F0F;
    dsel("R4", d, '0);
    rd("R4", 6'd40); chk("R4", rdata, pat(40));
    rd("R4", 6'd41); chk("R4", rdata, d);

    // R1: each select inactive in turn deselects; R7 continue-deselect
    rd("R1", 6'd12);
    cyc("R1", 1'b0, 1'b0, 3'b110, 1'b1, 6'd12, '0, '1, 1'b0); chk("R1", DW'(drive), '0);
    rd("R1", 6'd12);
    cyc("R1", 1'b0, 1'b0, 3'b000, 1'b1, 6'd12, '0, '1, 1'b0); chk("R1", DW'(drive), '0);
    rd("R1", 6'd12);
    cyc("R1", 1'b0, 1'b0, 3'b011, 1'b1, 6'd12, '0, '1, 1'b0); chk("R1", DW'(drive), '0);
    nxt("R7", '0, '1); chk("R7", DW'(drive), '0);
    rd("R1", 6'd12); chk("R1", rdata, pat(12));

    // random mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] s;
      logic [LANES-1:0] b;
      if (n == 2000) order = 1'b1;
      s = SEL_ON ^ {($urandom % 8 == 0), ($urandom % 8 == 0), ($urandom % 8 == 0)};
      b = ($urandom % 3 == 0) ? '0 : LANES'($urandom);
      cyc("R2", ($urandom % 10 == 0), 1'($urandom), s, 1'($urandom), AW'($urandom),
          DW'({$urandom, $urandom}), b, ($urandom % 5 == 0));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule